// File: doc/BRIEF.md
# Reduced-Select Multiplexer Function Generator

This block evaluates an arbitrary Boolean function of `NUM_VARS` inputs with a selector that has only half the usual number of legs. The leading `NUM_VARS-1` inputs steer the selector. Each leg carries a 2-bit residue code. The code makes that leg a constant 0, a constant 1, the trailing input, or the inverse of the trailing input. Any function of the inputs can therefore be expressed by choosing one residue per leg.

The residue codes live in a small register file. Software-free logic around the block loads it one leg at a time through a strobe, an index and a code. A second index reads any stored code back combinationally. A `full_mode` input reinterprets the same storage as a plain truth table. In that mode all `NUM_VARS` inputs act as the index and each stored bit is a fixed output value. The output is purely combinational in the data inputs. Only configuration changes wait for a clock edge.

Top module: `mux_fgen`

## Requirements
- R1: The input `in_vars[NUM_VARS-1]` is the first variable. In reduced mode (`full_mode`=0) the leg whose index equals `in_vars[NUM_VARS-1:1]` drives `fn_out`, and `in_vars[0]` is the trailing variable.
- R2: A selected leg holding code 2'b00 drives `fn_out` to 0.
- R3: A selected leg holding code 2'b01 drives `fn_out` to 1.
- R4: A selected leg holding code 2'b10 drives `fn_out` equal to `in_vars[0]`.
- R5: A selected leg holding code 2'b11 drives `fn_out` equal to the inverse of `in_vars[0]`.
- R6: In full mode (`full_mode`=1), `fn_out` is bit `in_vars[0]` of the code stored at leg `in_vars[NUM_VARS-1:1]`. The storage then reads as a truth table whose minterm m sits at flat bit m.
- R7: A clock edge with `rst_n` low clears every code to 2'b00. After that, `fn_out` is 0 for every input in both modes.
- R8: A clock edge with `wr_en` high stores `wr_code` at leg `wr_idx`. `rd_code` always shows the code of leg `rd_idx` without a clock.
- R9: A clock edge with `wr_en` low changes no stored code, whatever `wr_idx` and `wr_code` hold.
- R10: `fn_out` follows changes of `in_vars` and `full_mode` within the same clock cycle, with no clock edge in between.
- R11: With three variables, the leg codes 2'b11, 2'b11, 2'b00, 2'b01 at legs 0 to 3 realize the function that is true exactly on minterms 0, 2, 6 and 7.
- R12: With four variables, every function is realizable with eight legs. Random code sets match the function built from the codes over all 16 inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration storage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vars | input | NUM_VARS | Function inputs; MSB is the first variable |
| full_mode | input | 1 | 1 selects truth-table interpretation |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | NUM_VARS-1 | Leg index to write |
| wr_code | input | 2 | Residue code to store |
| rd_idx | input | NUM_VARS-1 | Leg index to read back |
| rd_code | output | 2 | Stored code of leg `rd_idx` |
| fn_out | output | 1 | Function output |

## Verification
The bench builds two instances. One uses `NUM_VARS`=4, with eight legs and 16 input points. The other uses `NUM_VARS`=3, with four legs and 8 input points. Both sizes are small enough to sweep every input combination under each configuration and in both modes. For every point, the bench forms the expected output arithmetically from its own copy of the written codes. The three-variable instance reaches the minterm 0, 2, 6, 7 example directly. The four-variable instance reaches random code sets, write and hold behaviour through readback, and mid-cycle input changes.

// File: rtl/mux_fgen_pkg.sv
// Package: shared residue encoding for the function generator.
// Assumes callers pass the trailing input variable as x_last.
package mux_fgen_pkg;

    typedef enum logic [1:0] {
        RES_ZERO   = 2'b00,
        RES_ONE    = 2'b01,
        RES_LAST   = 2'b10,
        RES_LAST_N = 2'b11
    } res_code_e;

    // Turns one residue code into the bit it forwards.
    function automatic logic resolve_residue(res_code_e code, logic x_last);
        case (code)
            RES_ZERO:   return 1'b0;
            RES_ONE:    return 1'b1;
            RES_LAST:   return x_last;
            default:    return ~x_last;
        endcase
    endfunction

endpackage

// File: rtl/fg_cfg_store.sv
// Configuration register file: one 2-bit residue code per selector leg.
// A write lands on the edge that samples wr_en high; readback is combinational.
// Assumes synchronous active-low reset that clears all codes to zero.
module fg_cfg_store #(
    parameter int IDX_W = 3,
    localparam int LEGS = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [1:0]         wr_code,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [1:0]         rd_code,
    output logic [2*LEGS-1:0]  cfg_flat
);

    logic [1:0] cfg_q [LEGS];

    // Purpose: clear on reset, otherwise store the strobed code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LEGS; i++) cfg_q[i] <= 2'b00;
        end else if (wr_en) begin
            cfg_q[wr_idx] <= wr_code;
        end
    end

    // Purpose: flatten the leg codes for the residue stage.
    always_comb begin
        for (int i = 0; i < LEGS; i++) cfg_flat[2*i +: 2] = cfg_q[i];
    end

    // Purpose: combinational readback of one leg.
    assign rd_code = cfg_q[rd_idx];

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_flat == '0);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$rose(rst_n)) |=> $stable(cfg_flat));

    a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx != $past(wr_idx) || rd_code == $past(wr_code)));

endmodule

// File: rtl/fg_residue.sv
// Per-leg residue stage: turns each stored code into the bit that leg carries.
// Reduced mode forwards 0, 1, x_last or ~x_last. Full mode picks code bit
// x_last, so two stored bits act as two truth-table rows.
module fg_residue
    import mux_fgen_pkg::*;
#(
    parameter int LEGS = 8
) (
    input  logic [2*LEGS-1:0] cfg_flat,
    input  logic              x_last,
    input  logic              full_mode,
    output logic [LEGS-1:0]   leg_val
);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic [1:0] code;
        assign code = cfg_flat[2*g +: 2];

        // Purpose: choose the bit this leg presents to the selector.
        always_comb begin
            if (full_mode) leg_val[g] = x_last ? code[1] : code[0];
            else           leg_val[g] = resolve_residue(res_code_e'(code), x_last);
        end
    end

endmodule

// File: rtl/fg_sel_tree.sv
// Binary selector tree of 2:1 stages in heap order; root stage uses sel MSB.
// Assumes SEL_W >= 1 and leaves numbered so leaf k is chosen by sel == k.
module fg_sel_tree #(
    parameter int SEL_W = 3,
    localparam int LEAVES = 1 << SEL_W,
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  logic [LEAVES-1:0] leaves,
    input  logic [SEL_W-1:0]  sel,
    output logic              y
);

    logic [NODES-1:0] node;

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        assign node[LEAVES-1+k] = leaves[k];
    end

    for (genvar lvl = 0; lvl < SEL_W; lvl++) begin : g_lvl
        for (genvar j = 0; j < (1 << lvl); j++) begin : g_node
            localparam int IDX = (1 << lvl) - 1 + j;
            // Purpose: one 2:1 stage steered by the select bit of this depth.
            assign node[IDX] = sel[SEL_W-1-lvl] ? node[2*IDX+2] : node[2*IDX+1];
        end
    end

    assign y = node[0];

endmodule

// File: rtl/mux_fgen.sv
// Top: reduced-select function generator of NUM_VARS inputs.
// The leading NUM_VARS-1 inputs index 2^(NUM_VARS-1) legs; the trailing
// input feeds the residue stage. Assumes NUM_VARS >= 2.
module mux_fgen #(
    parameter int NUM_VARS = 4,
    localparam int SEL_W = NUM_VARS - 1,
    localparam int LEGS  = 1 << SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VARS-1:0] in_vars,
    input  logic                full_mode,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_idx,
    input  logic [1:0]          wr_code,
    input  logic [SEL_W-1:0]    rd_idx,
    output logic [1:0]          rd_code,
    output logic                fn_out
);

    logic [2*LEGS-1:0] cfg_flat;
    logic [LEGS-1:0]   leg_val;

    fg_cfg_store #(.IDX_W(SEL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_code  (wr_code),
        .rd_idx   (rd_idx),
        .rd_code  (rd_code),
        .cfg_flat (cfg_flat)
    );

    fg_residue #(.LEGS(LEGS)) u_res (
        .cfg_flat  (cfg_flat),
        .x_last    (in_vars[0]),
        .full_mode (full_mode),
        .leg_val   (leg_val)
    );

    fg_sel_tree #(.SEL_W(SEL_W)) u_tree (
        .leaves (leg_val),
        .sel    (in_vars[NUM_VARS-1:1]),
        .y      (fn_out)
    );

    // Output checks relate readback of the selected leg to the tree output.
    a_r2_zero_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_mode && rd_idx == in_vars[NUM_VARS-1:1] && rd_code == 2'b00) |-> !fn_out);

    a_r3_one_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_mode && rd_idx == in_vars[NUM_VARS-1:1] && rd_code == 2'b01) |-> fn_out);

    a_r4_last_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_mode && rd_idx == in_vars[NUM_VARS-1:1] && rd_code == 2'b10) |-> fn_out == in_vars[0]);

    a_r5_inv_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_mode && rd_idx == in_vars[NUM_VARS-1:1] && rd_code == 2'b11) |-> fn_out != in_vars[0]);

    a_r6_table_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (full_mode && rd_idx == in_vars[NUM_VARS-1:1]) |-> fn_out == rd_code[in_vars[0]]);

endmodule

// File: tb/sim_mux_fgen.sv
// Bench: exhaustive input sweeps over a 4-variable and a 3-variable instance.
module sim_mux_fgen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Four-variable instance.
    logic [3:0] a_in = '0;
    logic       a_full = 1'b0;
    logic       a_wen = 1'b0;
    logic [2:0] a_widx = '0;
    logic [1:0] a_wcode = '0;
    logic [2:0] a_ridx = '0;
    logic [1:0] a_rcode;
    logic       a_out;
    logic [1:0] ref_cfg [8];

    mux_fgen #(.NUM_VARS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vars(a_in), .full_mode(a_full),
        .wr_en(a_wen), .wr_idx(a_widx), .wr_code(a_wcode),
        .rd_idx(a_ridx), .rd_code(a_rcode), .fn_out(a_out)
    );

    // Three-variable instance.
    logic [2:0] b_in = '0;
    logic       b_wen = 1'b0;
    logic [1:0] b_widx = '0;
    logic [1:0] b_wcode = '0;
    logic [1:0] b_ridx = '0;
    logic [1:0] b_rcode;
    logic       b_out;

    mux_fgen #(.NUM_VARS(3)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vars(b_in), .full_mode(1'b0),
        .wr_en(b_wen), .wr_idx(b_widx), .wr_code(b_wcode),
        .rd_idx(b_ridx), .rd_code(b_rcode), .fn_out(b_out)
    );

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_a(int idx, logic [1:0] code);
        @(negedge clk);
        a_wen = 1'b1; a_widx = idx[2:0]; a_wcode = code;
        @(negedge clk);
        a_wen = 1'b0;
        ref_cfg[idx] = code;
    endtask

    task automatic wr_b(int idx, logic [1:0] code);
        @(negedge clk);
        b_wen = 1'b1; b_widx = idx[1:0]; b_wcode = code;
        @(negedge clk);
        b_wen = 1'b0;
    endtask

    // R1/R12 sweep: expected from the bench copy of the codes.
    task automatic sweep_a(logic full);
        a_full = full;
        for (int x = 0; x < 16; x++) begin
            logic [1:0] c;
            logic       last;
            logic       exp;
            string      tag;
            a_in = x[3:0];
            a_ridx = x[3:1];
            c = ref_cfg[x >> 1];
            last = x[0];
            if (full) begin
                exp = c[last];
                tag = "R6 table";
            end else begin
                case (c)
                    2'b00: begin exp = 1'b0;  tag = "R2 zero";  end
                    2'b01: begin exp = 1'b1;  tag = "R3 one";   end
                    2'b10: begin exp = last;  tag = "R4 last";  end
                    default: begin exp = ~last; tag = "R5 inv"; end
                endcase
            end
            #1;
            check(tag, {1'b0, a_out}, {1'b0, exp});
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) ref_cfg[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state, codes cleared, output zero in both modes.
        for (int i = 0; i < 8; i++) begin
            a_ridx = i[2:0];
            #1;
            check("R7 code", a_rcode, 2'b00);
        end
        sweep_a(1'b0);
        sweep_a(1'b1);

        // R2..R5 directed: one of each code.
        wr_a(0, 2'b00); wr_a(1, 2'b01); wr_a(2, 2'b10); wr_a(3, 2'b11);
        wr_a(4, 2'b11); wr_a(5, 2'b10); wr_a(6, 2'b01); wr_a(7, 2'b00);
        // R8: readback of every leg after writes.
        for (int i = 0; i < 8; i++) begin
            a_ridx = i[2:0];
            #1;
            check("R8 readback", a_rcode, ref_cfg[i]);
        end
        sweep_a(1'b0);
        sweep_a(1'b1);

        // R9: strobe low with live index and code leaves storage untouched.
        @(negedge clk);
        a_widx = 3'd2; a_wcode = 2'b01;
        repeat (3) @(negedge clk);
        a_ridx = 3'd2;
        #1;
        check("R9 hold", a_rcode, 2'b10);

        // R10: mid-cycle input change reaches the output without an edge.
        a_full = 1'b0;
        @(posedge clk);
        #2 a_in = 4'b0100;
        #1 check("R10 comb low", {1'b0, a_out}, 2'b00);
        a_in = 4'b0101;
        #1 check("R10 comb high", {1'b0, a_out}, 2'b01);
        a_full = 1'b1;
        #1 check("R10 mode flip", {1'b0, a_out}, {1'b0, ref_cfg[2][1]});

        // R12: random code sets, both modes.
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 8; i++) wr_a(i, 2'($urandom_range(3, 0)));
            sweep_a(1'b0);
            sweep_a(1'b1);
        end

        // R11: three-variable example on minterms 0, 2, 6, 7.
        wr_b(0, 2'b11); wr_b(1, 2'b11); wr_b(2, 2'b00); wr_b(3, 2'b01);
        for (int x = 0; x < 8; x++) begin
            logic exp;
            b_in = x[2:0];
            b_ridx = x[2:1];
            exp = (x == 0 || x == 2 || x == 6 || x == 7);
            #1;
            check("R11 minterms", {1'b0, b_out}, {1'b0, exp});
        end

        // R7: reset clears programmed storage again.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) ref_cfg[i] = 2'b00;
        sweep_a(1'b1);
        b_ridx = 2'd3;
        #1 check("R7 reclear", b_rcode, 2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule